// File: doc/BRIEF.md
# Reset Sequencer with Strap Latching

This block produces the internal system reset of a small controller-class device. It takes two reset sources: an active-low board reset pin and a one-cycle reset request from an on-chip watchdog. The pin forces reset at once, without needing a clock. Its release passes through a clocked synchroniser, so the end of reset always lines up with the master clock. A watchdog request starts a fixed-length internal reset pulse instead.

Once reset ends, the block holds back the processor's first instruction fetch until a fixed number of master-clock cycles has gone by. It also forwards a copy of the master clock to an output pin, but only after the pin reset has been released. Two board straps, a boot-mode select and a debug tri-state select, are latched only when a pin reset ends. Watchdog resets keep the latched values. While the latched tri-state flag is set, a global kill disables every output driver.

Top module: `rstgen_core`

## Requirements
- R1: While `ext_rst_n_i` is low, `sys_rst_o` is high with no clock edge needed, `fetch_en_o` is low, and the latched boot and tri-state flags read 0.
- R2: After `ext_rst_n_i` rises, `sys_rst_o` stays high until the second rising edge of `clk_i` and falls just after that edge (two-flop synchroniser).
- R3: `fetch_en_o` is low whenever `sys_rst_o` is high. It rises just after the 80th rising edge of `clk_i` that follows the edge on which `sys_rst_o` fell. For a pin reset this is the 82nd edge after the pin rises.
- R4: The straps are latched only on the edge on which a pin reset releases `sys_rst_o`. Strap changes at any other time leave `boot_mode_o` and `tri_mode_o` unchanged.
- R5: A `wdog_req_i` high at a rising edge while `sys_rst_o` is low drives `sys_rst_o` high for exactly 16 cycles, starting just after that edge. `fetch_en_o` then returns 80 edges after the pulse ends, and the latched straps are kept.
- R6: A `wdog_req_i` seen while `sys_rst_o` is already high has no effect: it neither lengthens a running pulse nor starts a new one after it.
- R7: The pin has priority. Asserting `ext_rst_n_i` during a watchdog pulse or during a request ends the pulse, and the following release behaves as a full pin reset, including strap latching.
- R8: `clk_out_o` is low while `ext_rst_n_i` is low. It is enabled at the first falling edge of `clk_i` after `sys_rst_o` is released by the pin. From then on it equals `clk_i`, and it stays running during watchdog pulses.
- R9: `oe_kill_o` is high exactly when the latched tri-state flag `tri_mode_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| ext_rst_n_i | input | 1 | Board reset pin, active low, asynchronous assertion |
| wdog_req_i | input | 1 | Watchdog reset request, sampled on rising edges |
| strap_boot_i | input | 1 | Boot-mode strap |
| strap_tri_i | input | 1 | Debug tri-state strap |
| sys_rst_o | output | 1 | Internal system reset, active high |
| fetch_en_o | output | 1 | Permission for the first processor fetch |
| clk_out_o | output | 1 | Gated image of the master clock |
| boot_mode_o | output | 1 | Latched boot-mode flag |
| tri_mode_o | output | 1 | Latched tri-state flag |
| oe_kill_o | output | 1 | Global output-driver disable |

## Verification
The bench changes the straps both while reset is held and right after it is released. A design that samples the straps continuously, or one edge too early or too late, therefore reports the wrong boot or tri-state value. Watchdog pulses are run with new strap values present, so a design that re-latches the straps on a watchdog reset is caught. A second request is issued inside a running pulse, so a retriggering pulse would stretch `sys_rst_o` beyond 16 cycles. The pin is asserted in the middle of a pulse and together with a request. The fetch-enable edge is checked on the exact cycle, so an off-by-one fetch counter, or one that fails to restart after a watchdog pulse, shows up as `fetch_en_o` changing one cycle early or late.

// File: rtl/rstgen_pkg.sv
package rstgen_pkg;

    // Strap values held across watchdog resets
    typedef struct packed {
        logic boot;
        logic tri_en;
    } strap_t;

    localparam strap_t STRAP_DEFAULT = '{boot: 1'b0, tri_en: 1'b0};

    // State of the watchdog pulse stretcher
    typedef enum logic {
        WD_IDLE = 1'b0,
        WD_HOLD = 1'b1
    } wd_state_e;

    localparam int unsigned STEP_W = 16;

    // Increment that stops at a limit
    function automatic logic [STEP_W-1:0] sat_step(input logic [STEP_W-1:0] v,
                                                   input logic [STEP_W-1:0] lim);
        return (v >= lim) ? lim : v + 1'b1;
    endfunction

    function automatic int unsigned cnt_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rstgen_sync.sv
module rstgen_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic released_o,
    output logic release_pulse_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk_i or negedge arst_n_i) begin
                    if (!arst_n_i) chain_q[i] <= 1'b0;
                    else           chain_q[i] <= 1'b1;
                end
            end else begin : g_next
                always_ff @(posedge clk_i or negedge arst_n_i) begin
                    if (!arst_n_i) chain_q[i] <= 1'b0;
                    else           chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign released_o      = chain_q[STAGES-1];
    // High in the cycle before the last stage sets: the release edge comes next
    assign release_pulse_o = chain_q[STAGES-2] & ~chain_q[STAGES-1];

endmodule

// File: rtl/rstgen_wdpulse.sv
module rstgen_wdpulse
    import rstgen_pkg::*;
#(
    parameter int unsigned PULSE = 16
) (
    input  logic clk_i,
    input  logic arst_n_i,
    input  logic released_i,
    input  logic req_i,
    output logic active_o
);
    localparam int unsigned CW = cnt_width(PULSE);
    localparam logic [CW-1:0] LOAD = CW'(PULSE - 1);

    wd_state_e     state_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            state_q <= WD_IDLE;
            left_q  <= '0;
        end else begin
            case (state_q)
                WD_IDLE: begin
                    if (released_i && req_i) begin
                        state_q <= WD_HOLD;
                        left_q  <= LOAD;
                    end
                end
                WD_HOLD: begin
                    if (left_q == '0) state_q <= WD_IDLE;
                    else              left_q  <= left_q - 1'b1;
                end
                default: state_q <= WD_IDLE;
            endcase
        end
    end

    assign active_o = (state_q == WD_HOLD);

endmodule

// File: rtl/rstgen_fetchdly.sv
module rstgen_fetchdly
    import rstgen_pkg::*;
#(
    parameter int unsigned DLY = 80
) (
    input  logic clk_i,
    input  logic arst_n_i,
    input  logic hold_i,
    output logic ready_o
);
    localparam int unsigned W = $clog2(DLY + 1);
    localparam logic [W-1:0] LIMIT = W'(DLY);

    logic [W-1:0]      cnt_q;
    logic [STEP_W-1:0] step_w;

    assign step_w = sat_step(STEP_W'(cnt_q), STEP_W'(DLY));

    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i)   cnt_q <= '0;
        else if (hold_i) cnt_q <= '0;
        else             cnt_q <= W'(step_w);
    end

    assign ready_o = (cnt_q == LIMIT) && !hold_i;

endmodule

// File: rtl/rstgen_straps.sv
module rstgen_straps
    import rstgen_pkg::*;
(
    input  logic   clk_i,
    input  logic   arst_n_i,
    input  logic   capture_i,
    input  strap_t pins_i,
    output strap_t held_o
);
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i)      held_o <= STRAP_DEFAULT;
        else if (capture_i) held_o <= pins_i;
    end

endmodule

// File: rtl/rstgen_core.sv
module rstgen_core
    import rstgen_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FETCH_DLY   = 80,
    parameter int unsigned WD_PULSE    = 16
) (
    input  logic clk_i,
    input  logic ext_rst_n_i,
    input  logic wdog_req_i,
    input  logic strap_boot_i,
    input  logic strap_tri_i,
    output logic sys_rst_o,
    output logic fetch_en_o,
    output logic clk_out_o,
    output logic boot_mode_o,
    output logic tri_mode_o,
    output logic oe_kill_o
);
    logic   pin_released;
    logic   pin_release_edge;
    logic   wd_active;
    logic   rst_any;
    logic   clk_en_q;
    strap_t strap_in;
    strap_t strap_held;

    rstgen_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i           (clk_i),
        .arst_n_i        (ext_rst_n_i),
        .released_o      (pin_released),
        .release_pulse_o (pin_release_edge)
    );

    rstgen_wdpulse #(.PULSE(WD_PULSE)) u_wd (
        .clk_i      (clk_i),
        .arst_n_i   (ext_rst_n_i),
        .released_i (pin_released),
        .req_i      (wdog_req_i),
        .active_o   (wd_active)
    );

    assign rst_any = !pin_released || wd_active;

    rstgen_fetchdly #(.DLY(FETCH_DLY)) u_fetch (
        .clk_i    (clk_i),
        .arst_n_i (ext_rst_n_i),
        .hold_i   (rst_any),
        .ready_o  (fetch_en_o)
    );

    assign strap_in = '{boot: strap_boot_i, tri_en: strap_tri_i};

    rstgen_straps u_straps (
        .clk_i     (clk_i),
        .arst_n_i  (ext_rst_n_i),
        .capture_i (pin_release_edge),
        .pins_i    (strap_in),
        .held_o    (strap_held)
    );

    // Enable changes while the clock is low, so the image has no runt pulse
    always_ff @(negedge clk_i or negedge ext_rst_n_i) begin
        if (!ext_rst_n_i) clk_en_q <= 1'b0;
        else              clk_en_q <= pin_released;
    end

    assign clk_out_o   = clk_i & clk_en_q;
    assign sys_rst_o   = rst_any;
    assign boot_mode_o = strap_held.boot;
    assign tri_mode_o  = strap_held.tri_en;
    assign oe_kill_o   = strap_held.tri_en;

endmodule

// File: rtl/rstgen_core_chk.sv
module rstgen_core_chk #(
    parameter int unsigned FETCH_DLY = 80
) (
    input logic clk_i,
    input logic ext_rst_n_i,
    input logic wdog_req_i,
    input logic sys_rst_o,
    input logic fetch_en_o,
    input logic clk_out_o,
    input logic boot_mode_o,
    input logic tri_mode_o,
    input logic oe_kill_o
);
    logic [1:0] since_rise_q;
    logic [7:0] quiet_q;

    always_ff @(posedge clk_i or negedge ext_rst_n_i) begin
        if (!ext_rst_n_i)            since_rise_q <= '0;
        else if (since_rise_q != 2'd3) since_rise_q <= since_rise_q + 2'd1;
    end

    always_ff @(posedge clk_i or negedge ext_rst_n_i) begin
        if (!ext_rst_n_i)          quiet_q <= '0;
        else if (sys_rst_o)        quiet_q <= '0;
        else if (quiet_q != 8'hFF) quiet_q <= quiet_q + 8'd1;
    end

    AST_PIN_FORCES_RST: assert property (@(posedge clk_i)
        !ext_rst_n_i |-> sys_rst_o); // R1

    AST_FETCH_OUTSIDE_RST: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        fetch_en_o |-> !sys_rst_o); // R3

    AST_FETCH_AFTER_DELAY: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        $rose(fetch_en_o) |-> (quiet_q >= 8'(FETCH_DLY))); // R3

    AST_STRAPS_STABLE: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        (since_rise_q == 2'd3) |-> $stable({boot_mode_o, tri_mode_o})); // R4

    AST_WD_ENTERS_RST: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        (wdog_req_i && !sys_rst_o) |=> sys_rst_o); // R5

    AST_CLKOUT_QUIET: assert property (@(negedge clk_i)
        !ext_rst_n_i |-> !clk_out_o); // R8

    AST_KILL_MATCHES_TRI: assert property (@(posedge clk_i) disable iff (!ext_rst_n_i)
        (since_rise_q == 2'd3) |-> (oe_kill_o == tri_mode_o)); // R9

endmodule

bind rstgen_core rstgen_core_chk #(.FETCH_DLY(FETCH_DLY)) u_rstgen_core_chk (
    .clk_i       (clk_i),
    .ext_rst_n_i (ext_rst_n_i),
    .wdog_req_i  (wdog_req_i),
    .sys_rst_o   (sys_rst_o),
    .fetch_en_o  (fetch_en_o),
    .clk_out_o   (clk_out_o),
    .boot_mode_o (boot_mode_o),
    .tri_mode_o  (tri_mode_o),
    .oe_kill_o   (oe_kill_o)
);

// File: tb/rstgen_core_bench.sv
`timescale 1ns/1ps
module rstgen_core_bench;
    localparam int FETCH = 80;
    localparam int PULSE = 16;

    logic clk = 1'b0;
    logic pin_n, wdog, s_boot, s_tri;
    logic sys_rst, fetch_en, clk_out, boot_m, tri_m, oe_kill;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    // Behavioural reference state
    int since_rise = 0;
    int wd_left = 0;
    int fcnt = 0;
    bit rel = 0;
    bit en_exp = 0;
    bit exp_boot = 0;
    bit exp_tri = 0;

    always #10 clk = ~clk;

    rstgen_core u_rstgen_core (
        .clk_i        (clk),
        .ext_rst_n_i  (pin_n),
        .wdog_req_i   (wdog),
        .strap_boot_i (s_boot),
        .strap_tri_i  (s_tri),
        .sys_rst_o    (sys_rst),
        .fetch_en_o   (fetch_en),
        .clk_out_o    (clk_out),
        .boot_mode_o  (boot_m),
        .tri_mode_o   (tri_m),
        .oe_kill_o    (oe_kill)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #12;
    endtask

    // Model update on every rising edge, then compare away from the edges
    always @(posedge clk) begin
        bit sys_b;
        bit sys_e;
        string rtag;
        if (!pin_n) begin
            since_rise = 0; rel = 0; wd_left = 0; fcnt = 0;
            exp_boot = 0; exp_tri = 0; en_exp = 0;
        end else begin
            sys_b = !rel || (wd_left > 0);
            if (since_rise == 1) begin
                exp_boot = s_boot;
                exp_tri  = s_tri;
            end
            if (sys_b) fcnt = 0;
            else if (fcnt < FETCH) fcnt++;
            if (wd_left > 0) wd_left--;
            else if (rel && wdog) wd_left = PULSE;
            if (since_rise < 2) since_rise++;
            rel = (since_rise >= 2);
        end
        #5;
        sys_e = !pin_n || !rel || (wd_left > 0);
        rtag = !pin_n ? "R1" : (!rel ? "R2" : "R5/R6/R7");
        check({rtag, " sys_rst"}, sys_rst, sys_e);
        check("R3 fetch_en", fetch_en, (fcnt == FETCH) && !sys_e);
        check("R4 boot_mode", boot_m, exp_boot);
        check("R4 tri_mode", tri_m, exp_tri);
        check("R9 oe_kill", oe_kill, exp_tri);
        check("R8 clk_out high phase", clk_out, en_exp);
        #10;
        check("R8 clk_out low phase", clk_out, 1'b0);
    end

    always @(negedge clk) en_exp = rel && pin_n;

    initial begin
        pin_n = 1'b0; wdog = 1'b0; s_boot = 1'b1; s_tri = 1'b0;
        #2;
        check("R1 reset sys_rst", sys_rst, 1'b1);
        check("R1 reset fetch_en", fetch_en, 1'b0);
        check("R1 reset boot_mode", boot_m, 1'b0);
        check("R1 reset oe_kill", oe_kill, 1'b0);
        // First pin release; straps flip right after the capture edge (R4)
        cyc(5); pin_n = 1'b1;
        cyc(2); s_boot = 1'b0; s_tri = 1'b1;
        cyc(100);
        // Watchdog pulse with new straps present, plus a request inside it (R5, R6)
        wdog = 1'b1; cyc(1); wdog = 1'b0;
        cyc(3); wdog = 1'b1; cyc(1); wdog = 1'b0;
        cyc(110);
        // Pin reset latches tri-state (R4, R9)
        pin_n = 1'b0; cyc(4); pin_n = 1'b1;
        cyc(100);
        // Pin and watchdog together (R7)
        s_boot = 1'b1; s_tri = 1'b0;
        pin_n = 1'b0; wdog = 1'b1; cyc(3);
        wdog = 1'b0; pin_n = 1'b1;
        cyc(100);
        // Pin during a running pulse (R7)
        s_boot = 1'b0; s_tri = 1'b1;
        wdog = 1'b1; cyc(1); wdog = 1'b0;
        cyc(5); s_boot = 1'b1; pin_n = 1'b0;
        cyc(3); pin_n = 1'b1;
        cyc(100);
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        #4000000;
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R1-R9 watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule